// File: doc/BRIEF.md
# Packed Lane Adder/Subtractor

This block performs addition or subtraction on two 64-bit operands treated as vectors of independent integer lanes. One control selects the lane width: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. A second control selects add or subtract. The same operation runs on every lane in the same cycle.

Internally there is a single 64-bit ripple of carries. That ripple is cut at each lane's lowest bit according to the width control. Any carry or borrow leaving the top of a lane is dropped, so each lane wraps modulo 2^width. Subtraction is done as A + ~B + 1, with the +1 injected at the bottom bit of every lane. The result and a valid flag are captured in registers and appear one cycle after an accepted input.

Top module: `vlane_addsub`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `res_o` and `res_vld_o` become zero at that edge.
- R2: `res_vld_o` is high in the cycle after a cycle with `in_vld_i` high, and low otherwise.
- R3: `res_o` keeps its value in any cycle that follows a cycle with `in_vld_i` low.
- R4: With `width_i` = 2'b00, each byte lane k (bits 8k+7:8k) of the result equals (a_k + b_k) mod 256 for add (`sub_i`=0). For example, A0h + 70h gives 10h.
- R5: With `width_i` = 2'b01, each 16-bit lane k (bits 16k+15:16k) equals (a_k op b_k) mod 65536.
- R6: With `width_i` = 2'b10, each 32-bit lane k (bits 32k+31:32k) equals (a_k op b_k) mod 2^32.
- R7: With `sub_i`=1, each lane equals (a_k − b_k) mod 2^width. A borrow out of one lane never changes the next lane.
- R8: A carry out of a lane never changes a neighbouring lane. All-ones plus one gives zero in every lane, for every width.
- R9: `width_i` = 2'b11 is reserved. With valid high, it produces an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld_i | input | 1 | Operands valid this cycle |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| width_i | input | 2 | Lane width: 00 byte, 01 16-bit, 10 32-bit, 11 reserved |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand (subtrahend) |
| res_o | output | 64 | Registered packed result |
| res_vld_o | output | 1 | Result valid |

## Verification
The byte-mode case A0h + 70h = 10h in every lane is a single pattern that gives a different result for every lane width. It therefore separates correct lane cuts from missing or misplaced ones. All-ones plus one and zero minus one probe the carry and borrow at every lane boundary at once. A carry leaking across a boundary turns the expected zeros into ones.

Pseudo-random operands are run in all three widths, for both add and subtract, and compared with a per-lane modulo model. This catches faults in the lane-bottom injection of the +1. The reserved code, and idle cycles between valid inputs, show the zeroing and the hold behaviour.

// File: rtl/vlane_pkg.sv
// Package: shared lane-width encoding for the packed adder.
// Assumes: widths are powers of two dividing the datapath width.
package vlane_pkg;
    typedef enum logic [1:0] {
        LW_8   = 2'b00,
        LW_16  = 2'b01,
        LW_32  = 2'b10,
        LW_RSV = 2'b11
    } lane_w_e;
endpackage

// File: rtl/vlane_cut.sv
// Module: vlane_cut
// Produces, for each bit, a flag saying whether that bit is the lowest bit
// of a lane under the selected width.
// Assumes: DW is a multiple of 32.
module vlane_cut #(
    parameter int DW = 64
) (
    input  logic [1:0]    width_i,
    output logic [DW-1:0] cut_o
);
    import vlane_pkg::*;

    // purpose: mark lane-bottom bits for the chosen lane width
    always_comb begin
        for (int i = 0; i < DW; i++) begin
            unique case (lane_w_e'(width_i))
                LW_8:    cut_o[i] = (i % 8)  == 0;
                LW_16:   cut_o[i] = (i % 16) == 0;
                LW_32:   cut_o[i] = (i % 32) == 0;
                default: cut_o[i] = (i % 8)  == 0;
            endcase
        end
    end
endmodule

// File: rtl/vlane_chain.sv
// Module: vlane_chain
// A single ripple carry chain over DW bits. At every bit flagged by cut_i
// the incoming carry is replaced by inj_i, which is 1 for subtract and
// 0 for add. The carry out of the lane below is therefore discarded there.
// Assumes: b_i is already inverted for subtract.
module vlane_chain #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic [DW-1:0] cut_i,
    input  logic          inj_i,
    output logic [DW-1:0] sum_o
);
    logic [DW:0] cy;

    assign cy[0] = inj_i;

    for (genvar g = 0; g < DW; g++) begin : g_bit
        logic cin;
        // purpose: cut the carry at lane bottoms, otherwise ripple
        assign cin      = (g == 0) ? inj_i : (cut_i[g] ? inj_i : cy[g]);
        assign sum_o[g] = a_i[g] ^ b_i[g] ^ cin;
        assign cy[g+1]  = (a_i[g] & b_i[g]) | (cin & (a_i[g] ^ b_i[g]));
    end

    // purpose: bottom lane always starts from the injected bit
    always_comb begin
        assert (cut_i[0]) else $error("bit0 must be a lane bottom");
    end
endmodule

// File: rtl/vlane_addsub.sv
// Module: vlane_addsub (top)
// Packed integer add/subtract over lanes of 8, 16 or 32 bits.
// Each lane wraps modulo its width. The result is registered.
// Assumes: synchronous active-low reset; width code 2'b11 yields zero.
module vlane_addsub #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld_i,
    input  logic          sub_i,
    input  logic [1:0]    width_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] res_o,
    output logic          res_vld_o
);
    import vlane_pkg::*;

    logic [DW-1:0] cut;
    logic [DW-1:0] b_eff;
    logic [DW-1:0] sum;
    logic          rsv;

    vlane_cut #(.DW(DW)) u_cut (
        .width_i (width_i),
        .cut_o   (cut)
    );

    // purpose: invert subtrahend for two's-complement subtract
    assign b_eff = sub_i ? ~b_i : b_i;
    assign rsv   = (width_i == LW_RSV);

    vlane_chain #(.DW(DW)) u_chain (
        .a_i   (a_i),
        .b_i   (b_eff),
        .cut_i (cut),
        .inj_i (sub_i),
        .sum_o (sum)
    );

    // purpose: capture result and valid, zero on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o     <= '0;
            res_vld_o <= 1'b0;
        end else begin
            res_vld_o <= in_vld_i;
            if (in_vld_i) res_o <= rsv ? '0 : sum;
        end
    end

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (res_o == '0 && !res_vld_o));
    assert_vld_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o == $past(in_vld_i) || $past(!rst_n));
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vld_i && rst_n) |=> $stable(res_o));
    assert_rsv_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && width_i == 2'b11) |=> (res_o == '0));
    assert_byte_lane0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && width_i == 2'b00 && !sub_i) |=>
        (res_o[7:0] == 8'($past(a_i[7:0]) + $past(b_i[7:0]))));
endmodule

// File: tb/sim_vlane_addsub.sv
module sim_vlane_addsub;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_vld_i = 0;
    logic        sub_i = 0;
    logic [1:0]  width_i = 0;
    logic [63:0] a_i = 0, b_i = 0;
    logic [63:0] res_o;
    logic        res_vld_o;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    vlane_addsub u0 (.clk(clk), .rst_n(rst_n), .in_vld_i(in_vld_i),
        .sub_i(sub_i), .width_i(width_i), .a_i(a_i), .b_i(b_i),
        .res_o(res_o), .res_vld_o(res_vld_o));

    function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                          logic s, logic [1:0] w);
        logic [63:0] r = '0;
        int lw;
        if (w == 2'b11) return '0;
        lw = (w == 0) ? 8 : (w == 1) ? 16 : 32;
        for (int k = 0; k < 64 / lw; k++) begin
            logic [63:0] m = (lw == 32) ? 64'hFFFF_FFFF : ((64'd1 << lw) - 1);
            logic [63:0] x = (a >> (k * lw)) & m;
            logic [63:0] y = (b >> (k * lw)) & m;
            logic [63:0] z = (s ? (x - y) : (x + y)) & m;
            r |= z << (k * lw);
        end
        return r;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one valid op, sample after the capture edge
    task automatic op(string req, logic [63:0] a, logic [63:0] b,
                      logic s, logic [1:0] w);
        @(negedge clk);
        a_i = a; b_i = b; sub_i = s; width_i = w; in_vld_i = 1;
        @(negedge clk);
        in_vld_i = 0;
        chk(req, {63'd0, res_vld_o}, 64'd1);
        chk(req, res_o, model(a, b, s, w));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", res_o, 64'd0);
        chk("R1", {63'd0, res_vld_o}, 64'd0);
    endtask

    task automatic t_byte_add();
        op("R4", 64'hA0A0_A0A0_A0A0_A0A0, 64'h7070_7070_7070_7070, 0, 2'b00);
        chk("R4", res_o, 64'h1010_1010_1010_1010);
    endtask

    task automatic t_word();
        op("R5", 64'hA0A0_A0A0_A0A0_A0A0, 64'h7070_7070_7070_7070, 0, 2'b01);
        chk("R5", res_o, 64'h1110_1110_1110_1110);
    endtask

    task automatic t_dword();
        op("R6", 64'hA0A0_A0A0_A0A0_A0A0, 64'h7070_7070_7070_7070, 0, 2'b10);
        chk("R6", res_o, 64'h1111_1110_1111_1110);
    endtask

    task automatic t_carry_wrap();
        for (int w = 0; w < 3; w++) begin
            op("R8", '1, 64'h0000_0001_0001_0101 | (w == 0 ? 64'h0101_0101_0101_0101 :
               w == 1 ? 64'h0001_0001_0001_0001 : 64'h0000_0001_0000_0001), 0, 2'(w));
        end
        op("R8", '1, 64'h0101_0101_0101_0101, 0, 2'b00);
        chk("R8", res_o, 64'd0);
    endtask

    task automatic t_sub();
        op("R7", 64'd0, 64'h0101_0101_0101_0101, 1, 2'b00);
        chk("R7", res_o, 64'hFFFF_FFFF_FFFF_FFFF);
        op("R7", 64'h0000_0005_0000_0005, 64'h0000_0007_0000_0003, 1, 2'b10);
        chk("R7", res_o, 64'hFFFF_FFFE_0000_0002);
    endtask

    task automatic t_random();
        logic [63:0] a, b;
        for (int i = 0; i < 60; i++) begin
            a = {$urandom, $urandom}; b = {$urandom, $urandom};
            op(i % 3 == 0 ? "R4" : i % 3 == 1 ? "R5" : "R6",
               a, b, i[0] ^ i[2], 2'(i % 3));
            if (i[0] ^ i[2]) chk("R7", res_o, model(a, b, 1, 2'(i % 3)));
        end
    endtask

    task automatic t_hold_rsv();
        logic [63:0] keep;
        op("R2", 64'h1234, 64'h1111, 0, 2'b00);
        keep = res_o;
        @(negedge clk); a_i = '1; b_i = '1; width_i = 2'b01;
        @(negedge clk);
        chk("R3", res_o, keep);
        chk("R2", {63'd0, res_vld_o}, 64'd0);
        op("R9", 64'h55, 64'h22, 0, 2'b11);
        chk("R9", res_o, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_byte_add();
        t_word();
        t_dword();
        t_carry_wrap();
        t_sub();
        t_random();
        t_hold_rsv();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule